// File: doc/BRIEF.md
# Reference clock monitor

This block judges a reference clock that has already been synchronised into a faster local clock domain. Software or board logic picks one of four nominal reference rates with a two-bit select: 8 kHz, 1.544 MHz, 2.048 MHz or 19.44 MHz. For the chosen rate the block knows the nominal period in local-clock ticks. It measures every reference period against that nominal period.

The monitor declares the reference failed in three cases. The first is a gross frequency error, found from the sum of a fixed window of consecutive periods. The second is a single phase hit, meaning one period that is far from nominal. The third is a reference that stops toggling. Once failed, the reference is declared good again only after a rate-dependent run of consecutive clean periods, and only while the latest frequency verdict is in range. A level output reports the verdict. Two single-cycle pulses mark the moments the verdict changes, so a downstream holdover controller can react to the events.

Top module: `refmon_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `ref_ok`, `fail_pulse` and `restore_pulse` are all 0.
- R2: `rate_sel` encodes 0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz and 3 = 19.44 MHz, with nominal periods of NOM_R0..NOM_R3 local ticks. The sum of each group of WIN consecutive measured periods is compared with the limits floor(0.97·WIN·nom) and ceil(1.03·WIN·nom). A sum outside those limits is a failure.
- R3: For rates 1, 2 and 3, a single period that differs from the nominal period by more than half of it (integer nom/2) is a failure.
- R4: For rate 0, a period's distance from nominal never causes a failure on its own; only the window check and the loss check apply.
- R5: With rising edges present, 2·nom local cycles without a new rising edge is a failure.
- R6: After a failure or after reset, `ref_ok` rises at the reference edge that completes the required number of consecutive clean periods, provided the latest window verdict is in range. The count is 1 for rate 0, 64 for rates 1 and 2, and 512 for rate 3.
- R7: Any failure while counting clean periods restarts the count from zero.
- R8: `fail_pulse` is high for exactly the one cycle in which `ref_ok` has just fallen. `restore_pulse` is high for exactly the one cycle in which `ref_ok` has just risen. Neither pulse occurs at any other time.
- R9: The first rising edge after reset or after a loss failure only starts period timing. The gap before it is not measured as a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local measurement clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference clock, already synchronised to clk |
| rate_sel | input | 2 | Nominal rate select (0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz, 3 = 19.44 MHz) |
| ref_ok | output | 1 | High while the reference is judged good |
| fail_pulse | output | 1 | One-cycle pulse when ref_ok falls |
| restore_pulse | output | 1 | One-cycle pulse when ref_ok rises |

## Verification
The assertions check four things on every cycle:
- the pulses agree with the level edges of `ref_ok`, and the two pulses never appear together;
- a reference that has gone silent for twice its nominal period is never reported good;
- a restoration only happens in a cycle that holds a reference rising edge.

The other behaviours can only be shown by the bench's scenarios:
- the exact clean-period counts per rate, including the boundary one period short;
- the window limits, probed just inside and just outside them;
- the phase hits that leave the window sum unchanged;
- the 8 kHz exemption from phase checking;
- restarting the count after a failure;
- the gap after a loss that must not be measured as a period.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    typedef enum logic [1:0] {
        RATE_LOW   = 2'd0,
        RATE_1544K = 2'd1,
        RATE_2048K = 2'd2,
        RATE_19M   = 2'd3
    } rate_e;

    // lower bound of a window sum, 3 percent below nominal, rounded down
    function automatic int win_lo(input int nom, input int win);
        return (nom * win * 97) / 100;
    endfunction

    // upper bound of a window sum, 3 percent above nominal, rounded up
    function automatic int win_hi(input int nom, input int win);
        return (nom * win * 103 + 99) / 100;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/refmon_period.sv
module refmon_period #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic [CW-1:0] nom,
    output logic          per_vld,
    output logic [CW-1:0] per,
    output logic          tmo
);
    typedef struct packed {
        logic          ref_s;
        logic          have;
        logic [CW-1:0] cnt;
    } per_st_t;

    per_st_t st_d, st_q;
    logic          rise;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        rise    = ref_in & ~st_q.ref_s;
        cnt_inc = st_q.cnt + 1'b1;
        per     = cnt_inc;
        per_vld = rise & st_q.have;
        tmo     = st_q.have & ~rise & ({1'b0, cnt_inc} >= {nom, 1'b0});

        st_d.ref_s = ref_in;
        if (rise)
            st_d.cnt = '0;
        else if (!(&st_q.cnt))
            st_d.cnt = cnt_inc;
        st_d.have = rise | (st_q.have & ~tmo);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/refmon_judge.sv
module refmon_judge #(
    parameter int CW  = 10,
    parameter int SW  = 14,
    parameter int WIN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          per_vld,
    input  logic [CW-1:0] per,
    input  logic          tmo,
    input  logic [CW-1:0] nom,
    input  logic          chk_phase,
    input  logic [SW-1:0] lo_w,
    input  logic [SW-1:0] hi_w,
    output logic          hit,
    output logic          win_fail,
    output logic          freq_ok
);
    localparam int NW = $clog2(WIN + 1);

    typedef struct packed {
        logic [SW-1:0] sum;
        logic [NW-1:0] n;
        logic          bad;
    } jdg_st_t;

    jdg_st_t st_d, st_q;
    logic [CW-1:0] diff;
    logic [SW-1:0] acc;
    logic          done;
    logic          outside;

    always_comb begin
        st_d    = st_q;
        diff    = (per > nom) ? (per - nom) : (nom - per);
        hit     = per_vld & chk_phase & (diff > (nom >> 1));
        acc     = st_q.sum + SW'(per);
        done    = per_vld & (st_q.n == NW'(WIN - 1));
        outside = (acc < lo_w) | (acc > hi_w);
        win_fail = done & outside;

        if (tmo) begin
            st_d.sum = '0;
            st_d.n   = '0;
        end else if (per_vld) begin
            if (done) begin
                st_d.sum = '0;
                st_d.n   = '0;
                st_d.bad = outside;
            end else begin
                st_d.sum = acc;
                st_d.n   = st_q.n + 1'b1;
            end
        end
        freq_ok = ~st_d.bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/refmon_restore.sv
module refmon_restore #(
    parameter int HW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          per_vld,
    input  logic          hit,
    input  logic          win_fail,
    input  logic          tmo,
    input  logic          freq_ok,
    input  logic [HW-1:0] hold,
    output logic          ref_ok,
    output logic          fail_pulse,
    output logic          restore_pulse
);
    typedef struct packed {
        logic [HW-1:0] clean;
        logic          ok;
        logic          fall;
        logic          rise;
    } rst_st_t;

    rst_st_t st_d, st_q;
    logic fail_now;

    always_comb begin
        st_d     = st_q;
        fail_now = hit | win_fail | tmo;

        if (fail_now)
            st_d.clean = '0;
        else if (per_vld && !(&st_q.clean))
            st_d.clean = st_q.clean + 1'b1;

        if (fail_now)
            st_d.ok = 1'b0;
        else if (!st_q.ok && (st_d.clean >= hold) && freq_ok)
            st_d.ok = 1'b1;

        st_d.fall = st_q.ok & ~st_d.ok;
        st_d.rise = ~st_q.ok & st_d.ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ref_ok        = st_q.ok;
    assign fail_pulse    = st_q.fall;
    assign restore_pulse = st_q.rise;
endmodule

// File: rtl/refmon_top.sv
module refmon_top #(
    parameter int NOM_R0  = 200,
    parameter int NOM_R1  = 64,
    parameter int NOM_R2  = 48,
    parameter int NOM_R3  = 32,
    parameter int HOLD_R0 = 1,
    parameter int HOLD_R1 = 64,
    parameter int HOLD_R2 = 64,
    parameter int HOLD_R3 = 512,
    parameter int WIN     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic [1:0] rate_sel,
    output logic       ref_ok,
    output logic       fail_pulse,
    output logic       restore_pulse
);
    import refmon_pkg::*;

    localparam int NOM_MAX  = max4(NOM_R0, NOM_R1, NOM_R2, NOM_R3);
    localparam int HOLD_MAX = max4(HOLD_R0, HOLD_R1, HOLD_R2, HOLD_R3);
    localparam int CW = $clog2(2 * NOM_MAX + 2) + 1;
    localparam int SW = CW + $clog2(WIN) + 1;
    localparam int HW = $clog2(HOLD_MAX + 1) + 1;
    localparam int NOMS  [4] = '{NOM_R0, NOM_R1, NOM_R2, NOM_R3};
    localparam int HOLDS [4] = '{HOLD_R0, HOLD_R1, HOLD_R2, HOLD_R3};

    logic [CW-1:0] nom_tbl  [4];
    logic [SW-1:0] lo_tbl   [4];
    logic [SW-1:0] hi_tbl   [4];
    logic [HW-1:0] hold_tbl [4];

    for (genvar g = 0; g < 4; g++) begin : g_rate
        assign nom_tbl[g]  = CW'(NOMS[g]);
        assign lo_tbl[g]   = SW'(win_lo(NOMS[g], WIN));
        assign hi_tbl[g]   = SW'(win_hi(NOMS[g], WIN));
        assign hold_tbl[g] = HW'(HOLDS[g]);
    end

    logic [CW-1:0] nom_sel;
    logic          chk_phase;
    logic          per_vld, tmo, hit, win_fail, freq_ok;
    logic [CW-1:0] per;

    assign nom_sel   = nom_tbl[rate_sel];
    assign chk_phase = (rate_e'(rate_sel) != RATE_LOW);

    refmon_period #(.CW(CW)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_in  (ref_in),
        .nom     (nom_sel),
        .per_vld (per_vld),
        .per     (per),
        .tmo     (tmo)
    );

    refmon_judge #(.CW(CW), .SW(SW), .WIN(WIN)) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_vld   (per_vld),
        .per       (per),
        .tmo       (tmo),
        .nom       (nom_sel),
        .chk_phase (chk_phase),
        .lo_w      (lo_tbl[rate_sel]),
        .hi_w      (hi_tbl[rate_sel]),
        .hit       (hit),
        .win_fail  (win_fail),
        .freq_ok   (freq_ok)
    );

    refmon_restore #(.HW(HW)) u_restore (
        .clk           (clk),
        .rst_n         (rst_n),
        .per_vld       (per_vld),
        .hit           (hit),
        .win_fail      (win_fail),
        .tmo           (tmo),
        .freq_ok       (freq_ok),
        .hold          (hold_tbl[rate_sel]),
        .ref_ok        (ref_ok),
        .fail_pulse    (fail_pulse),
        .restore_pulse (restore_pulse)
    );
endmodule

// File: rtl/refmon_chk.sv
module refmon_chk #(
    parameter int NOM_R0 = 200,
    parameter int NOM_R1 = 64,
    parameter int NOM_R2 = 48,
    parameter int NOM_R3 = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_in,
    input logic [1:0] rate_sel,
    input logic       ref_ok,
    input logic       fail_pulse,
    input logic       restore_pulse
);
    logic        prev_c;
    logic        seen_c;
    logic [19:0] gap_c;
    int          nom_c;

    always_comb begin
        case (rate_sel)
            2'd0:    nom_c = NOM_R0;
            2'd1:    nom_c = NOM_R1;
            2'd2:    nom_c = NOM_R2;
            default: nom_c = NOM_R3;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_c <= 1'b0;
            seen_c <= 1'b0;
            gap_c  <= '0;
        end else begin
            prev_c <= ref_in;
            if (ref_in && !prev_c) begin
                seen_c <= 1'b1;
                gap_c  <= '0;
            end else if (!(&gap_c)) begin
                gap_c <= gap_c + 1'b1;
            end
        end
    end

    // R8: a fail pulse accompanies a falling level, and only then
    assert_fall_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_pulse |-> (!ref_ok && $past(ref_ok)));
    assert_fall_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_ok) |-> fail_pulse);
    // R8: a restore pulse accompanies a rising level, and only then
    assert_rise_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restore_pulse |-> (ref_ok && !$past(ref_ok)));
    assert_rise_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_ok) |-> restore_pulse);
    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail_pulse && restore_pulse));
    // R5: a reference silent for two nominal periods is never reported good
    assert_silent_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_c && (int'(gap_c) >= 2 * nom_c)) |-> !ref_ok);
    // R6: restoration only at a reference rising edge
    assert_restore_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_ok) |-> $past(ref_in && !prev_c));
endmodule

bind refmon_top refmon_chk #(
    .NOM_R0 (NOM_R0),
    .NOM_R1 (NOM_R1),
    .NOM_R2 (NOM_R2),
    .NOM_R3 (NOM_R3)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ref_in        (ref_in),
    .rate_sel      (rate_sel),
    .ref_ok        (ref_ok),
    .fail_pulse    (fail_pulse),
    .restore_pulse (restore_pulse)
);

// File: tb/sim_refmon_top.sv
module sim_refmon_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       ref_ok, fail_pulse, restore_pulse;

    int checks = 0;
    int errors = 0;
    int falls  = 0;
    int rises  = 0;
    bit done   = 1'b0;

    refmon_top u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_in        (ref_in),
        .rate_sel      (rate_sel),
        .ref_ok        (ref_ok),
        .fail_pulse    (fail_pulse),
        .restore_pulse (restore_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) begin
            falls = 0;
            rises = 0;
        end else begin
            falls = falls + int'(fail_pulse);
            rises = rises + int'(restore_pulse);
        end
    end

    // fields: rate[34:33] period[32:17] edges[16:1] expected ok[0]
    localparam logic [34:0] VECS [12] = '{
        {2'd0, 16'd200, 16'd1,   1'b0},  // R9 single edge measures nothing
        {2'd0, 16'd200, 16'd2,   1'b1},  // R6 one clean period at 8 kHz
        {2'd1, 16'd64,  16'd64,  1'b0},  // R6 63 clean periods
        {2'd1, 16'd64,  16'd65,  1'b1},  // R6 64 clean periods
        {2'd2, 16'd48,  16'd65,  1'b1},  // R6 64 clean periods
        {2'd3, 16'd32,  16'd512, 1'b0},  // R6 511 clean periods
        {2'd3, 16'd32,  16'd513, 1'b1},  // R6 512 clean periods
        {2'd3, 16'd34,  16'd100, 1'b0},  // R2 window sum 272 above 264
        {2'd3, 16'd33,  16'd530, 1'b1},  // R2 window sum 264 at limit
        {2'd1, 16'd67,  16'd100, 1'b0},  // R2 window sum 536 above 528
        {2'd1, 16'd66,  16'd100, 1'b1},  // R2 window sum 528 at limit
        {2'd0, 16'd220, 16'd10,  1'b0}   // R2 window sum 1760 above 1648
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] r);
        @(negedge clk);
        rst_n    = 1'b0;
        ref_in   = 1'b0;
        rate_sel = r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ref_cycles(input int n, input int per);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_in = 1'b1;
            repeat (per / 2) @(negedge clk);
            ref_in = 1'b0;
            repeat (per - per / 2 - 1) @(negedge clk);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(2'd1);
        check("R1 ok after reset", int'(ref_ok), 0);
        check("R1 pulses after reset", int'(fail_pulse | restore_pulse), 0);

        for (int i = 0; i < 12; i++) begin
            logic [34:0] v;
            v = VECS[i];
            do_reset(v[34:33]);
            ref_cycles(int'(v[16:1]), int'(v[32:17]));
            check($sformatf("vector %0d ok level", i), int'(ref_ok), int'(v[0]));
        end

        // R3 R7 R8 phase hits with preserved window sum at 1.544 MHz
        do_reset(2'd1);
        ref_cycles(70, 64);
        check("R8 restore pulse count", rises, 1);
        ref_cycles(1, 100);
        ref_cycles(1, 28);
        check("R3 phase hit drops ok", int'(ref_ok), 0);
        check("R8 fail pulse count", falls, 1);
        ref_cycles(50, 64);
        ref_cycles(1, 100);
        ref_cycles(1, 28);
        ref_cycles(50, 64);
        check("R7 count restarted by hit", int'(ref_ok), 0);
        ref_cycles(20, 64);
        check("R7 ok after full clean run", int'(ref_ok), 1);
        check("R8 pulse counts", falls * 10 + rises, 12);

        // R4 the same kind of disturbance is ignored at 8 kHz
        do_reset(2'd0);
        ref_cycles(12, 200);
        ref_cycles(1, 310);
        ref_cycles(1, 90);
        ref_cycles(10, 200);
        check("R4 ok kept at 8 kHz", int'(ref_ok), 1);
        check("R4 no fail pulse", falls, 0);

        // R5 loss of edges at 2.048 MHz
        do_reset(2'd2);
        ref_cycles(70, 48);
        repeat (40) @(negedge clk);
        check("R5 ok before loss limit", int'(ref_ok), 1);
        repeat (12) @(negedge clk);
        check("R5 ok after loss limit", int'(ref_ok), 0);
        check("R5 fail pulse on loss", falls, 1);

        // R9 gap before first edge after loss is not a period
        do_reset(2'd0);
        ref_cycles(3, 200);
        check("R9 ok before loss", int'(ref_ok), 1);
        repeat (450) @(negedge clk);
        check("R9 ok lost", int'(ref_ok), 0);
        ref_cycles(1, 200);
        check("R9 first edge only starts timing", int'(ref_ok), 0);
        ref_cycles(1, 200);
        check("R9 one period restores", int'(ref_ok), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule